// File: doc/BRIEF.md
# Stretchable External Data Bus Sequencer

This block runs the multiplexed external data-memory cycle for an 8051-style core. The core hands it one request at a time over a ready/valid handshake: a read or write flag, an address, write data and a 3-bit stretch code taken from a control register. The block drives the address latch enable, the active-low read and write strobes, a multiplexed low address/data port and a high address port. It returns read data together with a one-clock done pulse.

Each request is decoded against an optional on-chip data SRAM window. Hits go to an on-chip array interface, and the bus stays quiet for them. Misses run a full off-chip cycle. The length of the strobe is set per access by the stretch code, so slow peripherals can be reached without changing the core.

A suppression input holds the latch enable low whenever no off-chip access is in progress, which reduces emissions. When suppression is clear, the latch enable keeps toggling at one quarter of the clock rate.

Top module: `xbus_seq`

## Requirements
- R1: One machine cycle is four clocks. While no off-chip access is running and ale_suppress is 0, ale is high for exactly two clocks out of every four.
- R2: An access lasts 4·N clocks, where N is 2 for stretch code 0 and code+2 for codes 1 to 7. The code is captured when the request is accepted, so later changes to req_stretch do not affect an access in progress.
- R3: During an off-chip access, ale is high in clocks 0 and 1 and low in every later clock of that access. This holds whatever the value of ale_suppress.
- R4: During an off-chip access, ad_oe is 1 and ad_out equals the low address byte in clocks 0 and 1, and the port is released in clocks 2 and 3. A write drives its data from clock 4 to the last clock. A read never drives the port after clock 1.
- R5: In an off-chip read, rd_n is low from clock 4 through clock 4N−3. In an off-chip write, wr_n is low over the same clocks. The two strobes are never low together. a_hi carries the high address byte for the whole off-chip access and is 0 at all other times.
- R6: Read data is captured at the clock edge that ends clock 4N−3, which is the last clock with the read strobe low. It appears on rdata while done is high for the single clock 4N−1.
- R7: A request is on-chip when sram_en is 1 and its address is below 1024. With sram_en at 0, every address goes off-chip. An on-chip access keeps rd_n and wr_n high, ad_oe at 0 and a_hi at 0. It raises int_sel for the whole access, raises int_we for writes, presents int_addr and int_wdata, and takes read data from int_rdata.
- R8: With ale_suppress at 1, ale stays low during idle time and during on-chip accesses. With ale_suppress at 0, ale toggles during on-chip accesses as in R1.
- R9: req_ready is high only in the fourth clock of an idle machine cycle and is low for the whole access. A request kept valid while busy starts nothing.
- R10: After reset, rd_n and wr_n are high, done, ad_oe and int_sel are low, and ale follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_stretch | input | 3 | Stretch code |
| sram_en | input | 1 | On-chip data SRAM window enable |
| ale_suppress | input | 1 | Hold ale low outside off-chip accesses |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured read data |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Multiplexed low address / data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 8 | Multiplexed port input |
| a_hi | output | 8 | High address byte |
| int_sel | output | 1 | On-chip access active |
| int_we | output | 1 | On-chip write |
| int_addr | output | 10 | On-chip address |
| int_wdata | output | 8 | On-chip write data |
| int_rdata | input | 8 | On-chip read data |

## Verification
The bench sets ad_in and int_rdata to the correct value only during clock 4N−3 and to a wrong value on either side. A design that samples one edge early or late therefore returns the wrong byte. Stretch codes 0, 1 and 7 are run, and req_stretch is changed during each access, so a block that computes the wrong length or re-reads the code mid-access moves done and the strobe edges. The window edge is probed at 03FFh and 0400h with the window enabled, and at a low address with it disabled; a wrong comparison sends the access to the wrong side. ALE is checked with suppression set during both on-chip and off-chip accesses, and requests are held valid while busy to catch a second, unwanted start.

// File: rtl/xbus_pkg.sv
// Shared constants and types for the external data bus sequencer.
// Assumes a fixed four-clock machine cycle.
package xbus_pkg;
    localparam int PH_PER_MC = 4;
    localparam int PH_W      = 2;
    localparam int MIN_MC    = 2;   // length for stretch code 0
    localparam int MC_OFFSET = 2;   // length = code + offset for codes above 0

    typedef enum logic {
        XB_IDLE = 1'b0,
        XB_BUSY = 1'b1
    } xb_state_e;
endpackage

// File: rtl/xbus_phase.sv
// Phase and machine-cycle sequencing.
// Keeps a free-running 4-phase counter and, during an access, counts the
// machine cycles up to the latched length. Assumes accept arrives only in
// phase 3, so every access starts in phase 0.
module xbus_phase #(
    parameter int MC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic [MC_W-1:0]         n_mc,
    output logic [xbus_pkg::PH_W-1:0] ph,
    output logic [MC_W-1:0]         mc,
    output logic                    busy,
    output logic                    last
);
    import xbus_pkg::*;

    xb_state_e state;

    assign busy = (state == XB_BUSY);
    assign last = busy && (mc == n_mc - MC_W'(1)) && (ph == PH_W'(PH_PER_MC - 1));

    // Free-running phase within the machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= '0;
        else        ph <= ph + PH_W'(1);
    end

    // Access state and machine-cycle index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XB_IDLE;
            mc    <= '0;
        end else if (accept) begin
            state <= XB_BUSY;
            mc    <= '0;
        end else if (last) begin
            state <= XB_IDLE;
            mc    <= '0;
        end else if (busy && ph == PH_W'(PH_PER_MC - 1)) begin
            mc    <= mc + MC_W'(1);
        end
    end

    // R2
    mc_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mc < n_mc));

    // R9
    accept_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (!busy && ph == PH_W'(PH_PER_MC - 1)));
endmodule

// File: rtl/xbus_decode.sv
// Region decode: returns 1 when an address must use the external bus.
// Assumes the on-chip window starts at address zero.
module xbus_decode #(
    parameter int ADDR_W    = 16,
    parameter int INT_BYTES = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sram_en,
    output logic              ext
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(INT_BYTES);

    // An address is on-chip only when the window is enabled and the address is inside it.
    always_comb ext = !(sram_en && ({1'b0, addr} < LIMIT));
endmodule

// File: rtl/xbus_strobe.sv
// Bus strobe and timing-point generation from phase, machine-cycle index,
// access type and region. Purely combinational over registered state.
module xbus_strobe #(
    parameter int MC_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      busy,
    input  logic                      ext,
    input  logic                      wr,
    input  logic                      suppress,
    input  logic [xbus_pkg::PH_W-1:0] ph,
    input  logic [MC_W-1:0]           mc,
    input  logic [MC_W-1:0]           n_mc,
    output logic                      ale,
    output logic                      rd_n,
    output logic                      wr_n,
    output logic                      drv_addr,
    output logic                      drv_data,
    output logic                      sample,
    output logic                      done
);
    import xbus_pkg::*;

    logic first_mc, last_mc, ext_busy, strobe_win;

    // Position of the current clock within the access.
    always_comb begin
        first_mc = (mc == '0);
        last_mc  = (mc == n_mc - MC_W'(1));
        ext_busy = busy && ext;
    end

    // Strobe window: from the second machine cycle to two clocks before the end.
    always_comb strobe_win = ext_busy && !first_mc && !(last_mc && ph[1]);

    // Latch enable: one pulse for off-chip accesses, otherwise free toggle unless suppressed.
    always_comb begin
        if (ext_busy) ale = first_mc && !ph[1];
        else          ale = !suppress && !ph[1];
    end

    // Active-low strobes, port drive and timing points.
    always_comb begin
        rd_n     = !(strobe_win && !wr);
        wr_n     = !(strobe_win && wr);
        drv_addr = ext_busy && first_mc && !ph[1];
        drv_data = ext_busy && wr && !first_mc;
        sample   = busy && !wr && last_mc && (ph == PH_W'(1));
        done     = busy && last_mc && (ph == PH_W'(PH_PER_MC - 1));
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    ale_strobe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));
endmodule

// File: rtl/xbus_seq.sv
// External data bus sequencer top.
// Accepts one request per access over ready/valid, latches it, decodes the
// region and steers the bus or the on-chip array interface. Assumes the
// on-chip array answers combinationally on int_rdata while int_sel is high.
module xbus_seq #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int STR_W     = 3,
    parameter int INT_BYTES = 1024
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_wr,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    input  logic [STR_W-1:0]            req_stretch,
    input  logic                        sram_en,
    input  logic                        ale_suppress,
    output logic                        done,
    output logic [DATA_W-1:0]           rdata,
    output logic                        ale,
    output logic                        rd_n,
    output logic                        wr_n,
    output logic [DATA_W-1:0]           ad_out,
    output logic                        ad_oe,
    input  logic [DATA_W-1:0]           ad_in,
    output logic [ADDR_W-DATA_W-1:0]    a_hi,
    output logic                        int_sel,
    output logic                        int_we,
    output logic [$clog2(INT_BYTES)-1:0] int_addr,
    output logic [DATA_W-1:0]           int_wdata,
    input  logic [DATA_W-1:0]           int_rdata
);
    import xbus_pkg::*;

    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int INT_AW = $clog2(INT_BYTES);
    localparam int MAX_MC = (1 << STR_W) - 1 + MC_OFFSET;
    localparam int MC_W   = $clog2(MAX_MC + 1);

    logic                 accept, ext_d, busy, last, sample, drv_addr, drv_data;
    logic [PH_W-1:0]      ph;
    logic [MC_W-1:0]      mc, n_mc_d, n_mc_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic                 wr_q, ext_q;

    assign req_ready = !busy && (ph == PH_W'(PH_PER_MC - 1));
    assign accept    = req_valid && req_ready;

    // Access length in machine cycles from the stretch code.
    always_comb begin
        if (req_stretch == '0) n_mc_d = MC_W'(MIN_MC);
        else                   n_mc_d = MC_W'(req_stretch) + MC_W'(MC_OFFSET);
    end

    xbus_decode #(.ADDR_W(ADDR_W), .INT_BYTES(INT_BYTES)) u_decode (
        .addr    (req_addr),
        .sram_en (sram_en),
        .ext     (ext_d)
    );

    xbus_phase #(.MC_W(MC_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .n_mc   (n_mc_q),
        .ph     (ph),
        .mc     (mc),
        .busy   (busy),
        .last   (last)
    );

    xbus_strobe #(.MC_W(MC_W)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .ext      (ext_q),
        .wr       (wr_q),
        .suppress (ale_suppress),
        .ph       (ph),
        .mc       (mc),
        .n_mc     (n_mc_q),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .drv_addr (drv_addr),
        .drv_data (drv_data),
        .sample   (sample),
        .done     (done)
    );

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            ext_q   <= 1'b1;
            n_mc_q  <= MC_W'(MIN_MC);
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_wr;
            ext_q   <= ext_d;
            n_mc_q  <= n_mc_d;
        end
    end

    // Read data capture at the sampling point.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (sample) rdata <= ext_q ? ad_in : int_rdata;
    end

    // Multiplexed port and high address drive.
    always_comb begin
        ad_oe  = drv_addr || drv_data;
        ad_out = drv_addr ? addr_q[DATA_W-1:0] : (drv_data ? wdata_q : '0);
        a_hi   = (busy && ext_q) ? addr_q[ADDR_W-1:DATA_W] : '0;
    end

    // On-chip array interface.
    always_comb begin
        int_sel   = busy && !ext_q;
        int_we    = busy && !ext_q && wr_q;
        int_addr  = addr_q[INT_AW-1:0];
        int_wdata = wdata_q;
    end

    // R4
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R7
    onchip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> (rd_n && wr_n && !ad_oe && a_hi == '0));

    // R8
    ale_suppressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_suppress && int_sel) |-> !ale);

    // R3
    ale_opens_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ext_d) |=> ale);

    // R9
    ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
endmodule

// File: tb/tb_xbus_seq.sv
// Directed bench for xbus_seq: one task per scenario, each checking its own results.
module tb_xbus_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [2:0]  req_stretch = 3'd1;
    logic        sram_en = 1'b0, ale_suppress = 1'b0;
    logic [7:0]  ad_in = '0, int_rdata = '0;
    logic        req_ready, done, ale, rd_n, wr_n, ad_oe, int_sel, int_we;
    logic [7:0]  rdata, ad_out, a_hi, int_wdata;
    logic [9:0]  int_addr;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_stretch(req_stretch), .sram_en(sram_en), .ale_suppress(ale_suppress),
        .done(done), .rdata(rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi),
        .int_sel(int_sel), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_rdata(int_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one access and checks every clock of it.
    task automatic run_access(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                              input logic [2:0] code, input bit sen, input bit sup,
                              input bit exp_ext, input logic [7:0] good);
        int n, waited;
        bit e_ale, e_rd, e_wr, e_oe;
        n = (code == 3'd0) ? 2 : int'(code) + 2;
        @(negedge clk);
        sram_en = sen; ale_suppress = sup;
        req_valid = 1'b1; req_wr = wr; req_addr = addr; req_wdata = wd; req_stretch = code;
        ad_in = ~good; int_rdata = ~good;
        waited = 0;
        while (!req_ready) begin @(negedge clk); waited++; end
        chk(waited < 4, "R9", "ready wait", waited, 3);
        for (int t = 0; t < 4*n; t++) begin
            @(negedge clk);
            if (t == 0) begin
                // R2: stretch change and a new request while busy must not matter
                req_stretch = ~code; req_addr = ~addr; req_wdata = ~wd;
            end
            if (t == 4*n - 3) begin ad_in = good; int_rdata = good; end
            if (t == 4*n - 2) begin ad_in = ~good; int_rdata = ~good; end
            if (t == 4*n - 1) req_valid = 1'b0;
            e_ale = exp_ext ? (t < 2) : (!sup && (t % 4) < 2);
            e_rd  = !(exp_ext && !wr && t >= 4 && t < 4*n - 2);
            e_wr  = !(exp_ext && wr && t >= 4 && t < 4*n - 2);
            e_oe  = exp_ext && (t < 2 || (wr && t >= 4));
            chk(ale == e_ale, exp_ext ? "R3" : "R8", $sformatf("ale t=%0d", t), ale, e_ale);
            chk(rd_n == e_rd, "R5", $sformatf("rd_n t=%0d", t), rd_n, e_rd);
            chk(wr_n == e_wr, "R5", $sformatf("wr_n t=%0d", t), wr_n, e_wr);
            chk(ad_oe == e_oe, "R4", $sformatf("ad_oe t=%0d", t), ad_oe, e_oe);
            if (e_oe)
                chk(ad_out == ((t < 2) ? addr[7:0] : wd), "R4", $sformatf("ad_out t=%0d", t),
                    ad_out, (t < 2) ? addr[7:0] : wd);
            chk(a_hi == (exp_ext ? addr[15:8] : 8'h00), "R5", "a_hi", a_hi,
                exp_ext ? addr[15:8] : 8'h00);
            chk(int_sel == !exp_ext, "R7", "int_sel", int_sel, !exp_ext);
            chk(int_we == (!exp_ext && wr), "R7", "int_we", int_we, !exp_ext && wr);
            if (!exp_ext) begin
                chk(int_addr == addr[9:0], "R7", "int_addr", int_addr, addr[9:0]);
                chk(int_wdata == wd, "R7", "int_wdata", int_wdata, wd);
            end
            chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
            chk(done == (t == 4*n - 1), "R2", $sformatf("done t=%0d", t), done, t == 4*n - 1);
            if (t == 4*n - 1 && !wr)
                chk(rdata == good, "R6", "rdata", rdata, good);
        end
        // R9: a request held while busy must not start a second access
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!done && !int_sel && rd_n && wr_n, "R9", "idle after access",
                {done, int_sel, rd_n, wr_n}, 4'b0011);
        end
        req_stretch = 3'd1;
    endtask

    task automatic t_reset;
        int highs = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (ale) highs++;
            chk(rd_n && wr_n && !done && !ad_oe && !int_sel, "R10", "reset outputs",
                {rd_n, wr_n, done, ad_oe, int_sel}, 5'b11000);
        end
        chk(highs == 2, "R1", "idle ale highs per 4 clocks", highs, 2);
    endtask

    task automatic t_idle_suppress;
        ale_suppress = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!ale, "R8", "idle ale suppressed", ale, 0);
        end
        ale_suppress = 1'b0;
    endtask

    task automatic t_ext_reads;
        run_access(1'b0, 16'h12A5, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 8'h3C); // R2 code 0
        run_access(1'b0, 16'hBE21, 8'h00, 3'd1, 1'b0, 1'b0, 1'b1, 8'hA7); // R6 default length
        run_access(1'b0, 16'h7F0E, 8'h00, 3'd7, 1'b0, 1'b0, 1'b1, 8'h5A); // R2 code 7
    endtask

    task automatic t_ext_write_suppressed;
        run_access(1'b1, 16'hC3D4, 8'h96, 3'd2, 1'b0, 1'b1, 1'b1, 8'h00); // R3 ale with suppress
    endtask

    task automatic t_onchip;
        run_access(1'b0, 16'h03FF, 8'h00, 3'd1, 1'b1, 1'b1, 1'b0, 8'hE1); // R7 top of window, R8
        run_access(1'b1, 16'h0155, 8'h4B, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00); // R8 toggling
    endtask

    task automatic t_window_edges;
        run_access(1'b0, 16'h0400, 8'h00, 3'd1, 1'b1, 1'b0, 1'b1, 8'h19); // R7 just above
        run_access(1'b1, 16'h0010, 8'h6E, 3'd3, 1'b0, 1'b0, 1'b1, 8'h00); // R7 window off
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_suppress();
        t_ext_reads();
        t_ext_write_suppressed();
        t_onchip();
        t_window_edges();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", vectors, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule